// File: doc/BRIEF.md
# Refresh Backlog Scheduler

This block decides when a DRAM controller should spend a cycle slot on an auto-refresh. A down-counter measures the programmed refresh period; every time it runs out, one more refresh is owed and a small backlog counter grows. Each refresh the controller actually issues pays one back. Three urgency flags are decoded from the backlog. The two lower levels only ask for a refresh while the controller reports itself idle. The top level demands one ahead of any new access.

The request output follows a simple handshake. The request rises once urgency calls for it and stays up until the controller acknowledges it. A programmable recovery lockout follows, during which urgency is not re-evaluated. While the memory is in self-refresh, every counter in the block and the handshake freeze, and no request is presented.

Top module: `refresh_backlog_sched`

## Requirements
- R1: Reset loads the interval counter with `rate_i`. With self-refresh low it expires once every `rate_i`+1 rising edges. `backlog_o` rises by one on the edge that ends each expiry cycle, so k edges after reset release the backlog equals k/(`rate_i`+1), rounded down.
- R2: An issued refresh lowers `backlog_o` by one on that edge. An issued refresh is a rising edge with `req_o` and `ack_i` both high.
- R3: An interval expiry and an issued refresh on the same edge leave `backlog_o` unchanged.
- R4: `backlog_o` is 4 bits wide and saturates at 15. Further expiries leave it at 15.
- R5: `urg_lo_o` is high when the backlog is above 0. `urg_mid_o` is high when it is above 4, and `urg_hi_o` when it is above 7. All three follow `backlog_o` in the same cycle.
- R6: When the backlog is above 0 but not above 7, a request is raised only if `busy_i` is low at an edge. `req_o` then goes high after that edge.
- R7: When the backlog is above 7, a request is raised after the next edge whatever the value of `busy_i`.
- R8: Once raised, `req_o` stays high, whatever `busy_i` does, until an edge where `ack_i` is high.
- R9: After an issued refresh, `req_o` is low for exactly max(`trfc_i`,1) cycles, with `trfc_i` sampled at the issuing edge. Urgency is re-checked in the last of those cycles, so `req_o` may rise right after them.
- R10: While `self_refresh_i` is high, the interval counter, the backlog, the handshake state and the lockout count all hold. `req_o` is low and `ack_i` is ignored.
- R11: An active-low reset clears the backlog and the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 16 | Refresh period minus one, in cycles |
| trfc_i | input | 8 | Recovery lockout after a refresh, in cycles |
| self_refresh_i | input | 1 | Memory is in self-refresh; freezes the block |
| busy_i | input | 1 | Controller has access work pending |
| ack_i | input | 1 | Controller issues the requested refresh this cycle |
| req_o | output | 1 | Refresh request |
| urg_lo_o | output | 1 | Backlog above 0 |
| urg_mid_o | output | 1 | Backlog above 4 |
| urg_hi_o | output | 1 | Backlog above 7; refresh before any new access |
| backlog_o | output | 4 | Refreshes currently owed |

## Verification
The backlog moves on the rising edge that ends an expiry or issue cycle. The urgency flags follow it in the same cycle. The request appears one edge after the urgency condition is seen and drops on the acknowledging edge, then stays low for the lockout length. All inputs are driven and all outputs sampled on the falling edge. Each sample therefore reflects exactly the rising edges counted since reset release, and expected backlog values come from edge counts and the programmed period. The lockout is measured by counting low samples of the request after the acknowledge, over several lockout values including zero.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_WAIT = 2'd2
  } hs_state_e;

  // urgency thresholds: flag set when backlog is strictly above
  localparam int unsigned LVL_LO  = 0;
  localparam int unsigned LVL_MID = 4;
  localparam int unsigned LVL_HI  = 7;
endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
module rfsh_interval_timer #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              freeze_i,
  output logic              expire_o
);
  logic [RATE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= rate_i;
    else if (!freeze_i) begin
      if (cnt_q == '0)     cnt_q <= rate_i;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = !freeze_i && (cnt_q == '0);

  a_r1_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && cnt_q == '0) |=> (cnt_q == $past(rate_i)));
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r10_interval_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(cnt_q));
endmodule

// File: rtl/rfsh_backlog_counter.sv
`timescale 1ns/1ps
module rfsh_backlog_counter #(
  parameter int unsigned BL_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [BL_W-1:0] count_o
);
  localparam logic [BL_W-1:0] CNT_MAX = '1;

  logic [BL_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
        2'b01:   if (count_q != '0)      count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign count_o = count_q;

  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_MAX && inc_i && !dec_i) |=> (count_q == CNT_MAX));
  a_r3_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(count_q));
  a_r2_pay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
  a_r2_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (count_q != '0));
endmodule

// File: rtl/rfsh_urgency_decode.sv
`timescale 1ns/1ps
module rfsh_urgency_decode
  import rfsh_pkg::*;
#(
  parameter int unsigned BL_W = 4
) (
  input  logic [BL_W-1:0] count_i,
  output logic            lo_o,
  output logic            mid_o,
  output logic            hi_o
);
  assign lo_o  = count_i > BL_W'(LVL_LO);
  assign mid_o = count_i > BL_W'(LVL_MID);
  assign hi_o  = count_i > BL_W'(LVL_HI);
endmodule

// File: rtl/rfsh_handshake.sv
`timescale 1ns/1ps
module rfsh_handshake
  import rfsh_pkg::*;
#(
  parameter int unsigned TRFC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRFC_W-1:0] trfc_i,
  input  logic              pending_i,
  input  logic              urgent_i,
  input  logic              busy_i,
  input  logic              freeze_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              issue_o
);
  hs_state_e         state_q;
  logic [TRFC_W-1:0] wcnt_q;
  logic              want;

  // low levels wait for idle; top level preempts
  assign want    = pending_i && (urgent_i || !busy_i);
  assign req_o   = (state_q == HS_REQ) && !freeze_i;
  assign issue_o = req_o && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      wcnt_q  <= '0;
    end else if (!freeze_i) begin
      unique case (state_q)
        HS_IDLE: if (want) state_q <= HS_REQ;
        HS_REQ: if (ack_i) begin
          state_q <= HS_WAIT;
          wcnt_q  <= trfc_i;
        end
        HS_WAIT: begin
          if (wcnt_q <= TRFC_W'(1)) state_q <= want ? HS_REQ : HS_IDLE;
          else                      wcnt_q  <= wcnt_q - 1'b1;
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (state_q == HS_REQ));
  a_r9_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> !req_o);
  a_r6_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_IDLE && !freeze_i && !urgent_i && busy_i) |=> (state_q != HS_REQ));
  a_r7_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_IDLE && !freeze_i && urgent_i && pending_i) |=> (state_q == HS_REQ));
  a_r10_hs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> ($stable(state_q) && $stable(wcnt_q)));
endmodule

// File: rtl/refresh_backlog_sched.sv
`timescale 1ns/1ps
module refresh_backlog_sched #(
  parameter int unsigned RATE_W = 16,
  parameter int unsigned TRFC_W = 8,
  parameter int unsigned BL_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [TRFC_W-1:0] trfc_i,
  input  logic              self_refresh_i,
  input  logic              busy_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              urg_lo_o,
  output logic              urg_mid_o,
  output logic              urg_hi_o,
  output logic [BL_W-1:0]   backlog_o
);
  logic expire;
  logic issue;

  rfsh_interval_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rate_i   (rate_i),
    .freeze_i (self_refresh_i),
    .expire_o (expire)
  );

  rfsh_backlog_counter #(.BL_W(BL_W)) u_backlog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (expire),
    .dec_i   (issue),
    .count_o (backlog_o)
  );

  rfsh_urgency_decode #(.BL_W(BL_W)) u_decode (
    .count_i (backlog_o),
    .lo_o    (urg_lo_o),
    .mid_o   (urg_mid_o),
    .hi_o    (urg_hi_o)
  );

  rfsh_handshake #(.TRFC_W(TRFC_W)) u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trfc_i    (trfc_i),
    .pending_i (urg_lo_o),
    .urgent_i  (urg_hi_o),
    .busy_i    (busy_i),
    .freeze_i  (self_refresh_i),
    .ack_i     (ack_i),
    .req_o     (req_o),
    .issue_o   (issue)
  );

  a_r5_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urg_hi_o |-> (urg_mid_o && urg_lo_o));
  a_r10_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_refresh_i |=> (!self_refresh_i || $stable(backlog_o)));
endmodule

// File: tb/sim_refresh_backlog_sched.sv
`timescale 1ns/1ps
module sim_refresh_backlog_sched;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] rate;
  logic [7:0]  trfc;
  logic        sr, busy, ack;
  logic        req, ulo, umid, uhi;
  logic [3:0]  bl;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  refresh_backlog_sched u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rate_i(rate), .trfc_i(trfc),
    .self_refresh_i(sr), .busy_i(busy), .ack_i(ack),
    .req_o(req), .urg_lo_o(ulo), .urg_mid_o(umid), .urg_hi_o(uhi),
    .backlog_o(bl)
  );

  task automatic chk(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(int r);
    rst_ni = 1'b0; rate = 16'(r); ack = 1'b0; busy = 1'b1; sr = 1'b0;
    cyc(1);
    chk("R11 backlog in reset", bl, 0);
    chk("R11 req in reset", req, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    int e, prev, exp_bl, low;
    int tv[3];
    rst_ni = 1'b0; rate = 16'd3; trfc = 8'd2; sr = 1'b0; busy = 1'b1; ack = 1'b0;
    cyc(1);

    // sweep: accumulation, saturation, flags, preemptive request
    for (int r = 0; r < 4; r++) begin
      do_reset(r);
      prev = 0;
      for (int k = 1; k <= 16 * (r + 1) + 4; k++) begin
        cyc(1);
        e = k / (r + 1);
        if (e > 15) e = 15;
        chk(e < 15 ? "R1 backlog" : "R4 backlog saturated", bl, e);
        chk("R5 lo flag", ulo, int'(e > 0));
        chk("R5 mid flag", umid, int'(e > 4));
        chk("R5 hi flag", uhi, int'(e > 7));
        chk("R7 request while busy", req, int'(prev > 7));
        prev = e;
      end
    end

    // idle-gated request, hold, lockout
    do_reset(3);
    cyc(13);
    rate = 16'd1000;
    cyc(3);
    chk("R1 backlog after 16 edges", bl, 4);
    chk("R5 mid flag at 4", umid, 0);
    cyc(3);
    chk("R6 no request while busy", req, 0);
    busy = 1'b0;
    cyc(1);
    chk("R6 request when idle", req, 1);
    busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc(1);
      chk("R8 request held", req, 1);
    end
    busy = 1'b0;
    tv[0] = 3; tv[1] = 0; tv[2] = 1;
    exp_bl = 4;
    foreach (tv[i]) begin
      trfc = 8'(tv[i]);
      ack = 1'b1;
      cyc(1);
      ack = 1'b0;
      exp_bl--;
      chk("R2 backlog after issue", bl, exp_bl);
      low = 0;
      while (req == 1'b0 && low < 40) begin
        low++;
        cyc(1);
      end
      chk("R9 lockout length", low, tv[i] < 1 ? 1 : tv[i]);
    end
    busy = 1'b1;
    trfc = 8'd2;
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    chk("R2 backlog to zero", bl, 0);
    cyc(5);
    chk("R9 no request after lockout", req, 0);
    chk("R5 lo flag at zero", ulo, 0);

    // simultaneous expiry and issue
    do_reset(3);
    cyc(4);
    chk("R1 first expiry", bl, 1);
    busy = 1'b0;
    cyc(1);
    chk("R6 request", req, 1);
    cyc(2);
    chk("R1 backlog steady", bl, 1);
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    chk("R3 backlog unchanged", bl, 1);
    chk("R9 request dropped", req, 0);

    // self-refresh freeze
    do_reset(3);
    cyc(2);
    sr = 1'b1;
    cyc(20);
    chk("R10 backlog frozen", bl, 0);
    sr = 1'b0;
    cyc(1);
    chk("R10 interval resumed", bl, 0);
    cyc(1);
    chk("R10 expiry after resume", bl, 1);
    sr = 1'b1;
    busy = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cyc(1);
      chk("R10 no request in self-refresh", req, 0);
    end
    sr = 1'b0;
    cyc(1);
    chk("R10 request after exit", req, 1);
    sr = 1'b1;
    cyc(1);
    chk("R10 request masked", req, 0);
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    sr = 1'b0;
    #0;
    chk("R10 ack ignored", bl, 1);
    chk("R8 request still pending", req, 1);
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    chk("R2 issue after exit", bl, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule